// File: doc/BRIEF.md
# Strided Block Copy Engine

This engine moves a programmed number of bytes from one strided region of memory into another strided region, so that data laid out in one pitch can be repacked into a different pitch. Each side has its own line width and its own gap between lines. Both are given in units of 16 bytes. The engine walks the two sides independently. A line boundary on the source side skips the source gap, and a line boundary on the destination side skips the destination gap. Neither side waits for the other.

Software loads the addresses, the byte count and the four pitch fields, then pulses `start`. The engine reads through a byte-addressed read port with one cycle of latency and writes through a byte-addressed write port that carries byte enables. A move of up to 16 bytes takes one read cycle and one write cycle. Each move is sized so that it crosses no source line end, no destination line end and not the end of the count. When the last write has been issued, the engine raises a one-cycle completion interrupt. A configuration with a zero line width on either side is rejected without any memory traffic.

Top module: `rect_copy_dma`

## Requirements
- R1: After reset, `busy`, `done_irq`, `cfg_err`, `rd_en` and `wr_en` are all 0.
- R2: The line width and gap fields count 16-byte units. With SW = 16·`src_line`, SG = 16·`src_gap`, DW = 16·`dst_line` and DG = 16·`dst_gap`, byte k of the transfer (k from 0) is read from `src_base` + (k div SW)·(SW+SG) + (k mod SW) and written to `dst_base` + (k div DW)·(DW+DG) + (k mod DW).
- R3: Each move carries the smallest of four values: the bytes left in the current source line, the bytes left in the current destination line, the bytes left in the total count, and 16. Both line counters reload independently when they reach zero.
- R4: A move is one cycle with `rd_en`=1 at `rd_addr`, followed in the next cycle by `wr_en`=1. In that write cycle, byte j of `wr_data` is byte j of the `rd_data` returned for the read, where `rd_data` byte j holds memory byte `rd_addr`+j. Bit j of `wr_be` enables memory byte `wr_addr`+j, and the enabled bits are the lowest ones and are contiguous.
- R5: A `start` accepted while idle raises `busy` in the next cycle. A transfer of N moves keeps `busy` high for exactly 2N cycles.
- R6: `done_irq` is a single-cycle pulse in the cycle after the final write, and `busy` is 0 in that cycle.
- R7: If `src_line` or `dst_line` is zero when `start` is accepted, the engine performs no read and no write. In the next cycle `cfg_err`=1 and `done_irq` pulses. `cfg_err` holds its value until the next accepted `start`.
- R8: A `total_len` of 0 with valid widths completes the same way, with no memory access and with `cfg_err`=0.
- R9: A `start` pulse while `busy`=1 is ignored, and changes to the configuration inputs during a transfer have no effect on it. The configuration is captured when `start` is accepted.
- R10: No memory byte outside the destination footprint of R2 is written, including on a partial final move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Trigger pulse, accepted when idle |
| src_base | input | ADDR_W | First source byte address |
| dst_base | input | ADDR_W | First destination byte address |
| total_len | input | TOTAL_W | Bytes to copy |
| src_line | input | LINE_W | Source line width, 16-byte units |
| src_gap | input | LINE_W | Source gap between lines, 16-byte units |
| dst_line | input | LINE_W | Destination line width, 16-byte units |
| dst_gap | input | LINE_W | Destination gap between lines, 16-byte units |
| rd_en | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_data | input | 8·BEAT_BYTES | Read data, one cycle after the request |
| wr_en | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 8·BEAT_BYTES | Write data |
| wr_be | output | BEAT_BYTES | Byte enables, lane j goes to wr_addr+j |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | Completion pulse |
| cfg_err | output | 1 | Last start had a zero line width |

## Verification
The bench uses matched pitches and zero gaps so that the copy is plainly contiguous. It then uses a narrow source feeding a wider destination, and the reverse, each with gaps, to show that the two sides wrap and skip on their own schedules. Counts that are not a multiple of 16, and one below 16, test the partial final move and the byte enables. Zero widths, a zero count and a start pulse during a transfer cover the rejection and ignore paths. Randomized pitches and counts are compared byte for byte against a whole-memory image and a per-move size model.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } rcd_state_e;

  localparam int UNIT_SHIFT = 4;
endpackage

// File: rtl/rcd_walker.sv
module rcd_walker #(
  parameter int ADDR_W = 32,
  parameter int LB_W   = 12,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [LB_W-1:0]   line_bytes,
  input  logic [LB_W-1:0]   gap_bytes,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] ptr,
  output logic [LB_W-1:0]   rem
);
  logic [ADDR_W-1:0] ptr_q;
  logic [LB_W-1:0]   rem_q, line_q, gap_q;
  logic              line_end;

  assign line_end = (rem_q == LB_W'(step));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      rem_q  <= '0;
      line_q <= '0;
      gap_q  <= '0;
    end else if (load) begin
      ptr_q  <= base;
      rem_q  <= line_bytes;
      line_q <= line_bytes;
      gap_q  <= gap_bytes;
    end else if (adv) begin
      if (line_end) begin
        rem_q <= line_q;
        ptr_q <= ptr_q + ADDR_W'(step) + ADDR_W'(gap_q);
      end else begin
        rem_q <= rem_q - LB_W'(step);
        ptr_q <= ptr_q + ADDR_W'(step);
      end
    end
  end

  assign ptr = ptr_q;
  assign rem = rem_q;

  AST_REM_WITHIN_LINE: assert property (@(posedge clk) disable iff (rst) rem_q <= line_q); // R3
endmodule

// File: rtl/rcd_step.sv
module rcd_step #(
  parameter int LB_W       = 12,
  parameter int TOTAL_W    = 16,
  parameter int BEAT_BYTES = 16,
  parameter int STEP_W     = 5
) (
  input  logic [LB_W-1:0]       src_rem,
  input  logic [LB_W-1:0]       dst_rem,
  input  logic [TOTAL_W-1:0]    tot_rem,
  output logic [STEP_W-1:0]     step,
  output logic [BEAT_BYTES-1:0] be
);
  localparam int CW = (LB_W > TOTAL_W) ? LB_W : TOTAL_W;

  logic [CW-1:0] a, b, c, m1, m2;

  always_comb begin
    a  = CW'(src_rem);
    b  = CW'(dst_rem);
    c  = CW'(tot_rem);
    m1 = (a < b) ? a : b;
    m2 = (m1 < c) ? m1 : c;
    step = (m2 < CW'(BEAT_BYTES)) ? STEP_W'(m2) : STEP_W'(BEAT_BYTES);
  end

  for (genvar j = 0; j < BEAT_BYTES; j++) begin : g_lane
    assign be[j] = (step > STEP_W'(j));
  end
endmodule

// File: rtl/rect_copy_dma.sv
module rect_copy_dma #(
  parameter int ADDR_W     = 32,
  parameter int TOTAL_W    = 16,
  parameter int LINE_W     = 8,
  parameter int BEAT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       src_base,
  input  logic [ADDR_W-1:0]       dst_base,
  input  logic [TOTAL_W-1:0]      total_len,
  input  logic [LINE_W-1:0]       src_line,
  input  logic [LINE_W-1:0]       src_gap,
  input  logic [LINE_W-1:0]       dst_line,
  input  logic [LINE_W-1:0]       dst_gap,
  output logic                    rd_en,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic [8*BEAT_BYTES-1:0] rd_data,
  output logic                    wr_en,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [8*BEAT_BYTES-1:0] wr_data,
  output logic [BEAT_BYTES-1:0]   wr_be,
  output logic                    busy,
  output logic                    done_irq,
  output logic                    cfg_err
);
  import rcd_pkg::*;

  localparam int LB_W   = LINE_W + UNIT_SHIFT;
  localparam int STEP_W = $clog2(BEAT_BYTES + 1);

  rcd_state_e        state_q;
  logic [TOTAL_W-1:0] tot_q;
  logic              done_q, err_q;
  logic              bad_cfg, accept, load, adv, last;
  logic [STEP_W-1:0] step;
  logic [BEAT_BYTES-1:0] be;
  logic [LB_W-1:0]   src_rem, dst_rem;
  logic [ADDR_W-1:0] src_ptr, dst_ptr;

  assign bad_cfg = (src_line == '0) || (dst_line == '0);
  assign accept  = (state_q == ST_IDLE) && start;
  assign load    = accept && !bad_cfg && (total_len != '0);
  assign adv     = (state_q == ST_WRITE);
  assign last    = (tot_q == TOTAL_W'(step));

  rcd_walker #(.ADDR_W(ADDR_W), .LB_W(LB_W), .STEP_W(STEP_W)) u_src (
    .clk(clk), .rst(rst), .load(load), .base(src_base),
    .line_bytes({src_line, {UNIT_SHIFT{1'b0}}}),
    .gap_bytes({src_gap, {UNIT_SHIFT{1'b0}}}),
    .adv(adv), .step(step), .ptr(src_ptr), .rem(src_rem)
  );

  rcd_walker #(.ADDR_W(ADDR_W), .LB_W(LB_W), .STEP_W(STEP_W)) u_dst (
    .clk(clk), .rst(rst), .load(load), .base(dst_base),
    .line_bytes({dst_line, {UNIT_SHIFT{1'b0}}}),
    .gap_bytes({dst_gap, {UNIT_SHIFT{1'b0}}}),
    .adv(adv), .step(step), .ptr(dst_ptr), .rem(dst_rem)
  );

  rcd_step #(.LB_W(LB_W), .TOTAL_W(TOTAL_W), .BEAT_BYTES(BEAT_BYTES), .STEP_W(STEP_W)) u_step (
    .src_rem(src_rem), .dst_rem(dst_rem), .tot_rem(tot_q), .step(step), .be(be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tot_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            err_q <= bad_cfg;
            if (load) begin
              tot_q   <= total_len;
              state_q <= ST_READ;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        ST_READ: state_q <= ST_WRITE;
        ST_WRITE: begin
          tot_q <= tot_q - TOTAL_W'(step);
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en    = (state_q == ST_READ);
  assign rd_addr  = src_ptr;
  assign wr_en    = (state_q == ST_WRITE);
  assign wr_addr  = dst_ptr;
  assign wr_data  = rd_data;
  assign wr_be    = wr_en ? be : '0;
  assign busy     = (state_q != ST_IDLE);
  assign done_irq = done_q;
  assign cfg_err  = err_q;

  AST_RD_WR_EXCL:    assert property (@(posedge clk) disable iff (rst) !(rd_en && wr_en)); // R4
  AST_WR_AFTER_RD:   assert property (@(posedge clk) disable iff (rst) wr_en |-> $past(rd_en)); // R4
  AST_BE_CONTIG:     assert property (@(posedge clk) disable iff (rst) wr_en |-> (wr_be != '0) && (((wr_be + BEAT_BYTES'(1)) & wr_be) == '0)); // R4
  AST_IRQ_PULSE:     assert property (@(posedge clk) disable iff (rst) done_irq |=> !done_irq); // R6
  AST_IRQ_NOT_BUSY:  assert property (@(posedge clk) disable iff (rst) done_irq |-> !busy); // R6
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst) cfg_err |-> !rd_en && !wr_en); // R7
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start)); // R5
endmodule

// File: tb/rect_copy_dma_test.sv
`timescale 1ns/1ps
module rect_copy_dma_test;
  localparam int AW = 32, TW = 16, LW = 8, BB = 16;
  localparam int MEM = 8192;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [TW-1:0] total_len = '0;
  logic [LW-1:0] src_line = '0, src_gap = '0, dst_line = '0, dst_gap = '0;
  logic rd_en, wr_en, busy, done_irq, cfg_err;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [8*BB-1:0] rd_data, wr_data;
  logic [BB-1:0] wr_be;

  int checks = 0, fails = 0;
  logic [7:0] mem [0:MEM-1];
  logic [7:0] ref_mem [0:MEM-1];

  always #2.5 clk = ~clk;

  rect_copy_dma #(.ADDR_W(AW), .TOTAL_W(TW), .LINE_W(LW), .BEAT_BYTES(BB)) uut (
    .clk(clk), .rst(rst), .start(start), .src_base(src_base), .dst_base(dst_base),
    .total_len(total_len), .src_line(src_line), .src_gap(src_gap), .dst_line(dst_line),
    .dst_gap(dst_gap), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .busy(busy), .done_irq(done_irq),
    .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    if (wr_en)
      for (int j = 0; j < BB; j++)
        if (wr_be[j]) mem[(wr_addr + j) % MEM] = wr_data[8*j +: 8];
    if (rd_en)
      for (int j = 0; j < BB; j++)
        rd_data[8*j +: 8] <= mem[(rd_addr + j) % MEM];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lin_addr(int base, int k, int w, int g);
    return base + (k / w) * (w + g) + (k % w);
  endfunction

  function automatic int min4(int a, int b, int c, int d);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    if (d < m) m = d;
    return m;
  endfunction

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic run(input int sb, input int db, input int tot, input int sl, input int sg,
                     input int dl, input int dg, input bit inject);
    int sw, dw, si, di, tr, exp_step, beats, cyc, bad, first_bad, exp_n;
    bit expect_err, trivial, busy_drop;
    sw = sl * 16; dw = dl * 16;
    for (int i = 0; i < MEM; i++) begin
      mem[i] = 8'((i * 37 + 11) ^ (i >> 8));
      ref_mem[i] = mem[i];
    end
    expect_err = (sl == 0) || (dl == 0);
    trivial = expect_err || (tot == 0);
    if (!trivial)
      for (int k = 0; k < tot; k++)
        ref_mem[lin_addr(db, k, dw, dg * 16) % MEM] = mem[lin_addr(sb, k, sw, sg * 16) % MEM];
    exp_n = 0;
    if (!trivial) begin
      si = sw; di = dw; tr = tot;
      while (tr > 0) begin
        exp_step = min4(si, di, tr, 16);
        si -= exp_step; di -= exp_step; tr -= exp_step;
        if (si == 0) si = sw;
        if (di == 0) di = dw;
        exp_n++;
      end
    end
    src_base = AW'(sb); dst_base = AW'(db); total_len = TW'(tot);
    src_line = LW'(sl); src_gap = LW'(sg); dst_line = LW'(dl); dst_gap = LW'(dg);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (trivial) begin
      chk(done_irq == 1'b1, expect_err ? "R7 done pulse" : "R8 done pulse", done_irq, 1);
      chk(busy == 1'b0, "R8 busy stays low", busy, 0);
      chk(cfg_err == expect_err, expect_err ? "R7 cfg_err set" : "R8 cfg_err clear", cfg_err, expect_err);
      @(negedge clk);
      chk(done_irq == 1'b0 && rd_en == 1'b0 && wr_en == 1'b0, "R7 single pulse no access", done_irq, 0);
      chk(cfg_err == expect_err, "R7 cfg_err holds", cfg_err, expect_err);
    end else begin
      chk(busy == 1'b1, "R5 busy after start", busy, 1);
      si = sw; di = dw; tr = tot; beats = 0; cyc = 1; busy_drop = 0;
      while (!done_irq && cyc < 5000) begin
        if (!busy) busy_drop = 1;
        if (wr_en) begin
          exp_step = min4(si, di, tr, 16);
          chk($countones(wr_be) == exp_step, "R3 move size", $countones(wr_be), exp_step);
          si -= exp_step; di -= exp_step; tr -= exp_step;
          if (si == 0) si = sw;
          if (di == 0) di = dw;
          beats++;
        end
        if (inject && cyc == 3) begin
          start = 1'b1;
          src_base = AW'(sb + 64); dst_base = AW'(db + 32); total_len = TW'(tot + 5);
          src_line = LW'(sl + 1); dst_gap = LW'(dg + 2);
        end
        if (inject && cyc == 4) start = 1'b0;
        @(negedge clk);
        cyc++;
      end
      chk(done_irq == 1'b1, "R6 completion seen", done_irq, 1);
      chk(busy == 1'b0 && !busy_drop, "R6 busy low at done, R5 high before", busy, 0);
      chk(cyc == 2 * exp_n + 1, "R5 cycle count", cyc, 2 * exp_n + 1);
      chk(beats == exp_n, "R3 move count", beats, exp_n);
      chk(cfg_err == 1'b0, "R7 cfg_err clear on valid start", cfg_err, 0);
      @(negedge clk);
      chk(done_irq == 1'b0 && busy == 1'b0, inject ? "R9 late start ignored" : "R6 pulse width", done_irq, 0);
    end
    bad = 0; first_bad = -1;
    for (int i = 0; i < MEM; i++)
      if (mem[i] !== ref_mem[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    chk(bad == 0, "R2 R10 memory image", bad, 0);
    if (bad != 0)
      $display("  first mismatch at %0d: actual=%0d expected=%0d", first_bad, mem[first_bad], ref_mem[first_bad]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done_irq == 0 && cfg_err == 0 && rd_en == 0 && wr_en == 0,
        "R1 reset outputs", {busy, done_irq, cfg_err, rd_en, wr_en}, 0);
    run(0, 4096, 128, 2, 0, 2, 0, 0);      // contiguous, equal pitch
    run(16, 4200, 200, 1, 2, 3, 1, 0);     // narrow src into wider dst
    run(5, 4103, 150, 4, 1, 1, 3, 0);      // wide src into narrow dst, odd bases
    run(32, 4400, 7, 2, 1, 2, 1, 0);       // below one beat
    run(0, 4096, 0, 0, 0, 2, 0, 0);        // R7 zero source width
    run(0, 4096, 64, 2, 0, 0, 1, 0);       // R7 zero destination width
    run(0, 4096, 0, 2, 1, 2, 1, 0);        // R8 zero count
    run(64, 4160, 160, 2, 1, 1, 1, 1);     // R9 start during transfer
    for (int n = 0; n < 25; n++)
      run(int'($urandom % 1024), 4096 + int'($urandom % 1024), 1 + int'($urandom % 300),
          1 + int'($urandom % 4), int'($urandom % 4), 1 + int'($urandom % 4), int'($urandom % 4), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule